// File: doc/BRIEF.md
# Reloading Down-Counter Timer Channel

A single timer channel that counts down from a programmable start value. Each cycle in which the selected tick-enable is high, the count falls by one. When a tick arrives while the count is already zero, the counter loads the stored reload value in that same cycle and raises an internal expiry event. A qualifying expiry inverts the level of the interrupt output. The output does not pulse, so a downstream controller sees one edge per expiry, alternating between rising and falling.

The channel is programmed through plain write strobes. Each strobe shares one data bus, and there are strobes for the live count, the reload value and the two match registers. Per-channel control levels select enable, time base, overflow interrupt enable and pulse request. Two tick-enable inputs carry a slow time base and a fast time base; they are produced elsewhere. The count, reload and match values are always visible on readback ports. All inputs are level or strobe signals with no flow control, so no back-pressure applies: every strobe is taken in the cycle it is high. Bus decoding and tick generation are outside the block.

Top module: `reload_timer_chan`

## Requirements
- R1: While reset is held, and directly after it, the following all read zero: count, reload, both match registers, the interrupt level and the pulse indication. The fast time base is selected (`base_slow_o` = 0), whatever the control inputs are doing.
- R2: `base_slow_o` takes the value of `sel_slow` one cycle after it changes. From that edge on, only `tick_slow` (when 1) or only `tick_fast` (when 0) advances the counter. A tick on the other input has no effect.
- R3: While enabled, each selected tick lowers the count by one. A tick at count zero loads the reload value in that same cycle and counts as an expiry.
- R4: `irq_o` inverts on every expiry that qualifies. An expiry qualifies when the channel is enabled and either `ovf_irq_en` is 1 or a match register holds zero. In every other cycle `irq_o` holds its level.
- R5: A count write sets the count to `wr_data` only while `chan_en` is 1. While the channel is disabled, a count write leaves the count unchanged.
- R6: A reload write stores `wr_data` as the reload value and also loads it into the count on the same edge, whether or not the channel is enabled. It takes priority over a count write in the same cycle.
- R7: While `chan_en` is 0 the counter does not count. It holds the stored reload value from the next edge on.
- R8: Bit 0 of `wr_match` writes match register 0 and bit 1 writes match register 1. A nonzero write is ignored and the register keeps its value. A zero write is stored.
- R9: `pulse_on_o` follows `pulse_req` one cycle later only when the channel index `CHAN_IDX` is 4 or more. On lower channels it stays 0.
- R10: With a reload value of zero, every selected tick while enabled is an expiry, so `irq_o` inverts on each such tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 1 | Channel enable level |
| sel_slow | input | 1 | 1 selects the slow time base, 0 the fast one |
| ovf_irq_en | input | 1 | Overflow interrupt enable |
| pulse_req | input | 1 | Pulse mode request |
| tick_slow | input | 1 | Slow time-base tick enable |
| tick_fast | input | 1 | Fast time-base tick enable |
| wr_count | input | 1 | Count write strobe |
| wr_reload | input | 1 | Reload write strobe |
| wr_match | input | 2 | Match register write strobes, bit n for register n |
| wr_data | input | CNT_W | Write data shared by all strobes |
| count_o | output | CNT_W | Live count |
| reload_o | output | CNT_W | Stored reload value |
| match0_o | output | CNT_W | Match register 0 |
| match1_o | output | CNT_W | Match register 1 |
| base_slow_o | output | 1 | Time base in use, 1 for slow |
| pulse_on_o | output | 1 | Pulse mode in effect |
| irq_o | output | 1 | Level-toggle interrupt output |

## Verification
The count is visible on every cycle, so a wrong decrement, reload or ignored-write decision shows on `count_o` at the edge right after the offending cycle. A wrong interrupt qualification is different: an extra or missing toggle inverts the phase of `irq_o`. That wrong phase then persists, so it shows at the first expiry check and at every check after it. A time-base select that is wrong or stale shows one cycle after `sel_slow` changes, as a count that either moves or holds when only the unselected tick is high.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;
  typedef enum logic {
    BASE_FAST = 1'b0,
    BASE_SLOW = 1'b1
  } tick_base_e;

  localparam int NUM_MATCH     = 2;
  localparam int PULSE_MIN_IDX = 4;
endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel
  import tmr_chan_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_slow_i,
  input  logic       tick_slow_i,
  input  logic       tick_fast_i,
  output tick_base_e base_o,
  output logic       tick_o
);
  tick_base_e base_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) base_q <= BASE_FAST;
    else         base_q <= sel_slow_i ? BASE_SLOW : BASE_FAST;
  end

  assign base_o = base_q;
  assign tick_o = (base_q == BASE_SLOW) ? tick_slow_i : tick_fast_i;

  // R1
  base_reset_chk: assert property (@(posedge clk_i) !rst_ni |=> base_q == BASE_FAST);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             wr_count_i,
  input  logic             wr_reload_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] reload_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] cnt_q, cnt_d, reload_q;
  logic             at_zero;

  assign at_zero  = (cnt_q == ZERO);
  assign expire_o = en_i && tick_i && at_zero && !wr_reload_i && !wr_count_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)          reload_q <= ZERO;
    else if (wr_reload_i) reload_q <= wr_data_i;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (wr_reload_i)     cnt_d = wr_data_i;
    else if (!en_i)      cnt_d = reload_q;
    else if (wr_count_i) cnt_d = wr_data_i;
    else if (tick_i)     cnt_d = at_zero ? reload_q : cnt_q - ONE;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) cnt_q <= ZERO;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o    = cnt_q;
  assign reload_o = reload_q;

  // R3
  dec_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && !wr_reload_i && !wr_count_i && !at_zero)
      |=> cnt_q == $past(cnt_q) - ONE);
  // R3
  expire_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> cnt_q == reload_q);
  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == reload_q);
  // R6
  reload_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_reload_i |=> cnt_q == reload_q);
endmodule

// File: rtl/tmr_match_regs.sv
module tmr_match_regs
  import tmr_chan_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_MATCH-1:0]           wr_i,
  input  logic [CNT_W-1:0]               wr_data_i,
  output logic [NUM_MATCH-1:0][CNT_W-1:0] match_o,
  output logic                           any_zero_o
);
  logic [NUM_MATCH-1:0][CNT_W-1:0] match_q;
  logic [NUM_MATCH-1:0]            is_zero;
  logic                            data_zero;

  assign data_zero = (wr_data_i == '0);

  for (genvar g = 0; g < NUM_MATCH; g++) begin : g_match
    always_ff @(posedge clk_i) begin
      if (!rst_ni)                   match_q[g] <= '0;
      else if (wr_i[g] && data_zero) match_q[g] <= wr_data_i;
    end
    assign is_zero[g] = (match_q[g] == '0);

    // R8
    nonzero_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i[g] && !data_zero) |=> $stable(match_q[g]));
  end

  assign match_o    = match_q;
  assign any_zero_o = |is_zero;
endmodule

// File: rtl/tmr_irq_level.sv
module tmr_irq_level (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic ovf_en_i,
  input  logic match_zero_i,
  output logic irq_o
);
  logic irq_q, qualify;

  assign qualify = expire_i && (ovf_en_i || match_zero_i);

  always_ff @(posedge clk_i) begin
    if (!rst_ni)      irq_q <= 1'b0;
    else if (qualify) irq_q <= ~irq_q;
  end

  assign irq_o = irq_q;

  // R4
  irq_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qualify |=> irq_q != $past(irq_q));
  // R4
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !qualify |=> $stable(irq_q));
endmodule

// File: rtl/reload_timer_chan.sv
module reload_timer_chan
  import tmr_chan_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int CHAN_IDX = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 chan_en,
  input  logic                 sel_slow,
  input  logic                 ovf_irq_en,
  input  logic                 pulse_req,
  input  logic                 tick_slow,
  input  logic                 tick_fast,
  input  logic                 wr_count,
  input  logic                 wr_reload,
  input  logic [NUM_MATCH-1:0] wr_match,
  input  logic [CNT_W-1:0]     wr_data,
  output logic [CNT_W-1:0]     count_o,
  output logic [CNT_W-1:0]     reload_o,
  output logic [CNT_W-1:0]     match0_o,
  output logic [CNT_W-1:0]     match1_o,
  output logic                 base_slow_o,
  output logic                 pulse_on_o,
  output logic                 irq_o
);
  localparam bit PULSE_OK = (CHAN_IDX >= PULSE_MIN_IDX);

  tick_base_e                      base;
  logic                            tick;
  logic                            expire;
  logic                            match_zero;
  logic [NUM_MATCH-1:0][CNT_W-1:0] match_vals;
  logic                            pulse_q;

  tmr_tick_sel u_tick_sel (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .sel_slow_i  (sel_slow),
    .tick_slow_i (tick_slow),
    .tick_fast_i (tick_fast),
    .base_o      (base),
    .tick_o      (tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .en_i        (chan_en),
    .tick_i      (tick),
    .wr_count_i  (wr_count),
    .wr_reload_i (wr_reload),
    .wr_data_i   (wr_data),
    .cnt_o       (count_o),
    .reload_o    (reload_o),
    .expire_o    (expire)
  );

  tmr_match_regs #(.CNT_W(CNT_W)) u_match (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wr_i       (wr_match),
    .wr_data_i  (wr_data),
    .match_o    (match_vals),
    .any_zero_o (match_zero)
  );

  tmr_irq_level u_irq (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .expire_i     (expire),
    .ovf_en_i     (ovf_irq_en),
    .match_zero_i (match_zero),
    .irq_o        (irq_o)
  );

  if (PULSE_OK) begin : g_pulse
    always_ff @(posedge clk) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= pulse_req;
    end
  end else begin : g_no_pulse
    always_ff @(posedge clk) pulse_q <= 1'b0;
  end

  assign match0_o    = match_vals[0];
  assign match1_o    = match_vals[1];
  assign base_slow_o = (base == BASE_SLOW);
  assign pulse_on_o  = pulse_q;

  // R4
  irq_quiet_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> $stable(irq_o));
  // R9
  pulse_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    PULSE_OK |=> pulse_on_o == $past(pulse_req));
endmodule

// File: tb/reload_timer_chan_tb.sv
module reload_timer_chan_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        chan_en, sel_slow, ovf_irq_en, pulse_req;
  logic        tick_slow, tick_fast, wr_count, wr_reload;
  logic [1:0]  wr_match;
  logic [31:0] wr_data;
  logic [31:0] count_o, reload_o, match0_o, match1_o;
  logic        base_slow_o, pulse_on_o, irq_o;
  logic [31:0] h_count, h_reload, h_m0, h_m1;
  logic        h_base, h_pulse, h_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [31:0] cnt;
    logic        irq;
    string       req;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  reload_timer_chan #(.CNT_W(32), .CHAN_IDX(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .sel_slow(sel_slow),
    .ovf_irq_en(ovf_irq_en), .pulse_req(pulse_req), .tick_slow(tick_slow),
    .tick_fast(tick_fast), .wr_count(wr_count), .wr_reload(wr_reload),
    .wr_match(wr_match), .wr_data(wr_data), .count_o(count_o),
    .reload_o(reload_o), .match0_o(match0_o), .match1_o(match1_o),
    .base_slow_o(base_slow_o), .pulse_on_o(pulse_on_o), .irq_o(irq_o)
  );

  reload_timer_chan #(.CNT_W(32), .CHAN_IDX(5)) u_dut_hi (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .sel_slow(sel_slow),
    .ovf_irq_en(ovf_irq_en), .pulse_req(pulse_req), .tick_slow(tick_slow),
    .tick_fast(tick_fast), .wr_count(wr_count), .wr_reload(wr_reload),
    .wr_match(wr_match), .wr_data(wr_data), .count_o(h_count),
    .reload_o(h_reload), .match0_o(h_m0), .match1_o(h_m1),
    .base_slow_o(h_base), .pulse_on_o(h_pulse), .irq_o(h_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops one expectation per clock edge and compares it
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check({e.req, " count"}, count_o, e.cnt);
      check({e.req, " irq"}, {31'd0, irq_o}, {31'd0, e.irq});
    end
  end

  // driver: queue the expected result of the coming edge, then advance
  task automatic step(input logic [31:0] c, input logic i, input string req);
    exp_t e;
    e.cnt = c; e.irq = i; e.req = req;
    sb.push_back(e);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clr_strobes();
    wr_count = 0; wr_reload = 0; wr_match = 2'b00; wr_data = '0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; chan_en = 0; ovf_irq_en = 0; tick_slow = 0; tick_fast = 0;
    clr_strobes();
    sel_slow = 1; pulse_req = 1;
    repeat (3) @(negedge clk);
    // R1: reset state despite active controls
    check("R1 base", {31'd0, base_slow_o}, 32'd0);
    check("R1 pulse", {31'd0, h_pulse}, 32'd0);
    check("R1 count", count_o, 32'd0);
    check("R1 reload", reload_o, 32'd0);
    check("R1 match0", match0_o, 32'd0);
    check("R1 match1", match1_o, 32'd0);
    check("R1 irq", {31'd0, irq_o}, 32'd0);
    sel_slow = 0; pulse_req = 0;
    rst_n = 1;
    @(negedge clk);

    // R6: reload write while disabled loads counter
    wr_reload = 1; wr_data = 32'd3;
    step(32'd3, 1'b0, "R6");
    check("R6 reload", reload_o, 32'd3);
    clr_strobes();

    // R5: count write while disabled ignored
    wr_count = 1; wr_data = 32'd7;
    step(32'd3, 1'b0, "R5");
    clr_strobes();

    // R3/R4: fast ticks, overflow irq disabled but match regs zero
    chan_en = 1; tick_fast = 1;
    step(32'd2, 1'b0, "R3");
    step(32'd1, 1'b0, "R3");
    step(32'd0, 1'b0, "R3");
    step(32'd3, 1'b1, "R4");
    step(32'd2, 1'b1, "R3");
    step(32'd1, 1'b1, "R3");
    step(32'd0, 1'b1, "R3");
    step(32'd3, 1'b0, "R4");

    // R2: only unselected tick present -> hold
    tick_fast = 0; tick_slow = 1;
    step(32'd3, 1'b0, "R2");
    sel_slow = 1; tick_slow = 0;
    step(32'd3, 1'b0, "R2");
    check("R2 base", {31'd0, base_slow_o}, 32'd1);
    tick_slow = 1;
    step(32'd2, 1'b0, "R2");
    tick_slow = 0; tick_fast = 1;
    step(32'd2, 1'b0, "R2");
    tick_fast = 0;

    // R5: count write while enabled
    wr_count = 1; wr_data = 32'd10;
    step(32'd10, 1'b0, "R5");
    clr_strobes();
    tick_slow = 1;
    step(32'd9, 1'b0, "R3");
    tick_slow = 0;

    // R6: reload beats count write
    wr_count = 1; wr_reload = 1; wr_data = 32'd5;
    step(32'd5, 1'b0, "R6");
    check("R6 reload prio", reload_o, 32'd5);
    clr_strobes();
    tick_slow = 1;
    step(32'd4, 1'b0, "R3");

    // R7: disable reloads and stops
    chan_en = 0;
    step(32'd5, 1'b0, "R7");
    step(32'd5, 1'b0, "R7");

    // R10: zero reload -> expiry every tick
    tick_slow = 0;
    wr_reload = 1; wr_data = 32'd0;
    step(32'd0, 1'b0, "R6");
    clr_strobes();
    chan_en = 1; tick_slow = 1;
    step(32'd0, 1'b1, "R10");
    step(32'd0, 1'b0, "R10");
    step(32'd0, 1'b1, "R10");
    tick_slow = 0;
    step(32'd0, 1'b1, "R4");

    // R8: nonzero match writes ignored, zero stored
    wr_match = 2'b01; wr_data = 32'd9;
    step(32'd0, 1'b1, "R8");
    check("R8 match0", match0_o, 32'd0);
    wr_match = 2'b10; wr_data = 32'd6;
    step(32'd0, 1'b1, "R8");
    check("R8 match1", match1_o, 32'd0);
    wr_match = 2'b11; wr_data = 32'd0;
    step(32'd0, 1'b1, "R8");
    check("R8 match0 zero", match0_o, 32'd0);
    clr_strobes();

    // R4: overflow enable also qualifies
    ovf_irq_en = 1; tick_slow = 1;
    step(32'd0, 1'b0, "R4");
    tick_slow = 0; chan_en = 0;
    step(32'd0, 1'b0, "R4");

    // R9: pulse only on high channel index
    pulse_req = 1;
    @(posedge clk); @(negedge clk);
    check("R9 low chan", {31'd0, pulse_on_o}, 32'd0);
    check("R9 high chan", {31'd0, h_pulse}, 32'd1);
    pulse_req = 0;
    @(posedge clk); @(negedge clk);
    check("R9 high chan off", {31'd0, h_pulse}, 32'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule